// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Register Front End

This block is the digital front end of a two-channel parallel-input digital-to-analog converter, built in synchronous logic on a system clock. A host writes a code word over a parallel data bus. An active-low chip select and a channel-select line steer that word into one of two staging registers. Each channel also has an active-low load line that moves the staged word into the channel's output register, and that output register is the code the converter would use.

The load lines are level-sensitive. While a load line is low, its output register follows the staging register. When the load line returns high, the output register keeps the value it held at that moment. Software can stage both channels one after the other and then pulse both load lines together, so that both outputs change on the same clock edge. An active-low clear input empties every register to code zero asynchronously. An active-low shutdown input only lowers an output-enable flag, and writes and loads continue while it is low. A synchronous active-high system reset also clears the registers and the flag. Every host input passes through a two-stage synchronizer before it is used.

Top module: `dac_dual_frontend`

## Requirements
- R1: While `rst` is high at a clock edge, both output registers and both staging registers are cleared to zero and `out_en` is 0. After `rst` falls, `out_en` rises 2 clock edges later if `shdn_n` is high.
- R2: `cs_n` = 0 with `sel_a` = 1 writes `data` into the channel A staging register, and `sel_a` = 0 writes channel B. With the load line already low, the new word appears at the output 4 clock edges after the pins change: 2 synchronizer edges, 1 staging edge and 1 output edge.
- R3: While `cs_n` is high, both staging registers hold their contents whatever `data` and `sel_a` do.
- R4: While a channel's load line (`ld_a_n` or `ld_b_n`) is low, that channel's output register follows its staging register.
- R5: On the rising edge of a load line, the output register keeps the staging value of that moment. While the load line stays high, later writes to the staging register do not change the output.
- R6: Driving both load lines low together updates `dac_a` and `dac_b` on the same clock edge.
- R7: `clr_n` = 0 forces `dac_a` and `dac_b` to 0 at once, without waiting for a clock edge, whatever the other inputs are doing.
- R8: After `clr_n` returns high, every register holds zero until a new write or load occurs. A load with nothing written since the clear gives output 0.
- R9: `shdn_n` has no effect on writes or loads. Staging and output registers keep updating while it is low.
- R10: `out_en` follows `shdn_n` with 2 clock edges of latency. When shutdown ends, the outputs show the most recent output-register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cs_n | input | 1 | Active-low write strobe for the staging registers |
| sel_a | input | 1 | Channel select: 1 = channel A, 0 = channel B |
| data | input | DW | Parallel code word |
| ld_a_n | input | 1 | Active-low, level-sensitive load for channel A |
| ld_b_n | input | 1 | Active-low, level-sensitive load for channel B |
| clr_n | input | 1 | Active-low asynchronous clear to code zero |
| shdn_n | input | 1 | Active-low shutdown; only lowers `out_en` |
| dac_a | output | DW | Channel A output register |
| dac_b | output | DW | Channel B output register |
| out_en | output | 1 | Output enable flag, low during shutdown |

## Verification
The hardest case to reach is the corner where a load line rises on the same synchronized edge that a new word lands in the staging register. In that case the output must keep the older staging value. Random phases change chip select, address, data, both load lines and shutdown together and hold each combination long enough for the synchronizers to settle, so this collision happens many times. Clear pulses are also placed in the middle of a cycle, and the outputs are checked before the next clock edge to show that the clear acts without a clock.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int NCH = 2;
  // channel ordering: index 0 is channel A (select high), index 1 is B
  typedef enum logic {
    CH_B = 1'b0,
    CH_A = 1'b1
  } chan_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RV = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      s1 <= RV;
      q  <= RV;
    end else if (rst) begin
      s1 <= RV;
      q  <= RV;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/dacfe_channel.sv
module dacfe_channel #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          en,
  input  logic          wr,
  input  logic          ld_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dac_q
);
  logic [DW-1:0] in_q;
  logic          ld_prev;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      in_q    <= '0;
      dac_q   <= '0;
      ld_prev <= 1'b1;
    end else if (rst) begin
      in_q    <= '0;
      dac_q   <= '0;
      ld_prev <= 1'b1;
    end else begin
      ld_prev <= ld_n;
      if (en && wr) in_q <= din;
      // transparent while low, plus one capture on the rising edge
      if (en && (!ld_n || !ld_prev)) dac_q <= in_q;
    end
  end

  // R3
  in_hold_chk: assert property (@(posedge clk) disable iff (rst || !en)
    !wr |=> $stable(in_q));

  // R4
  dac_follow_chk: assert property (@(posedge clk) disable iff (rst || !en)
    !ld_n |=> (dac_q == $past(in_q)));

  // R5
  dac_capture_chk: assert property (@(posedge clk) disable iff (rst || !en)
    $rose(ld_n) |=> (dac_q == $past(in_q)));

  // R5
  dac_latched_chk: assert property (@(posedge clk) disable iff (rst || !en)
    (ld_n && ld_prev) |=> $stable(dac_q));
endmodule

// File: rtl/dac_dual_frontend.sv
module dac_dual_frontend
  import dacfe_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sel_a,
  input  logic [DW-1:0] data,
  input  logic          ld_a_n,
  input  logic          ld_b_n,
  input  logic          clr_n,
  input  logic          shdn_n,
  output logic [DW-1:0] dac_a,
  output logic [DW-1:0] dac_b,
  output logic          out_en
);
  localparam int CW = 2 + NCH;
  localparam logic [CW-1:0] CTRL_IDLE = {1'b1, {NCH{1'b1}}, 1'b0};

  logic [CW-1:0]  ctrl_s;
  logic [DW-1:0]  data_s;
  logic           clr_ok;
  logic           cs_s;
  logic           sel_s;
  logic [NCH-1:0] ld_s;
  logic [DW-1:0]  dac_w [NCH];

  // bundle: {cs_n, ld_b_n, ld_a_n, sel_a}
  dacfe_sync #(.W(CW), .RV(CTRL_IDLE)) u_ctrl_sync (
    .clk(clk), .rst(rst), .clr_n(clr_n),
    .d({cs_n, ld_b_n, ld_a_n, sel_a}), .q(ctrl_s)
  );

  dacfe_sync #(.W(DW), .RV('0)) u_data_sync (
    .clk(clk), .rst(rst), .clr_n(clr_n), .d(data), .q(data_s)
  );

  // release of the clear is seen two edges after clr_n rises
  dacfe_sync #(.W(1), .RV(1'b0)) u_clr_sync (
    .clk(clk), .rst(rst), .clr_n(clr_n), .d(1'b1), .q(clr_ok)
  );

  // shutdown is not touched by the clear; second stage is the flag
  dacfe_sync #(.W(1), .RV(1'b0)) u_shdn_sync (
    .clk(clk), .rst(rst), .clr_n(1'b1), .d(shdn_n), .q(out_en)
  );

  assign sel_s = ctrl_s[0];
  assign ld_s  = ctrl_s[NCH:1];
  assign cs_s  = ctrl_s[CW-1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam chan_e ME = (i == 0) ? CH_A : CH_B;
    logic wr;
    assign wr = !cs_s && (chan_e'(sel_s) == ME);

    dacfe_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .clr_n(clr_n), .en(clr_ok),
      .wr(wr), .ld_n(ld_s[i]), .din(data_s), .dac_q(dac_w[i])
    );
  end

  assign dac_a = dac_w[0];
  assign dac_b = dac_w[1];

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (dac_a == '0 && dac_b == '0));

  // R1
  rst_flag_chk: assert property (@(posedge clk)
    rst |=> (!out_en && dac_a == '0 && dac_b == '0));
endmodule

// File: tb/sim_dac_dual_frontend.sv
module sim_dac_dual_frontend;
  localparam int DW = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, cs_n, sel_a, ld_a_n, ld_b_n, clr_n, shdn_n;
  logic [DW-1:0] data, dac_a, dac_b;
  logic          out_en;

  dac_dual_frontend #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sel_a(sel_a), .data(data),
    .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .clr_n(clr_n), .shdn_n(shdn_n),
    .dac_a(dac_a), .dac_b(dac_b), .out_en(out_en)
  );

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  logic [DW-1:0] m_in [2];
  logic [DW-1:0] m_dac [2];

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] next_in(input logic [DW-1:0] cur, input logic wr,
                                             input logic [DW-1:0] d);
    return wr ? d : cur;
  endfunction

  function automatic logic [DW-1:0] next_dac(input logic [DW-1:0] cur, input logic ld_low,
                                              input logic [DW-1:0] inv);
    return ld_low ? inv : cur;
  endfunction

  // hold one pin combination long enough to settle, then compare
  task automatic step(input logic c, input logic s, input logic [DW-1:0] d,
                      input logic la, input logic lb, input logic sh, input string req);
    @(negedge clk);
    cs_n = c; sel_a = s; data = d; ld_a_n = la; ld_b_n = lb; shdn_n = sh;
    repeat (6) @(negedge clk);
    m_in[0]  = next_in(m_in[0], !c && s, d);
    m_in[1]  = next_in(m_in[1], !c && !s, d);
    m_dac[0] = next_dac(m_dac[0], !la, m_in[0]);
    m_dac[1] = next_dac(m_dac[1], !lb, m_in[1]);
    chk({req, " dac_a"}, dac_a, m_dac[0]);
    chk({req, " dac_b"}, dac_b, m_dac[1]);
    chk({req, " R10 out_en"}, {{(DW-1){1'b0}}, out_en}, {{(DW-1){1'b0}}, sh});
  endtask

  task automatic clear_pulse(input string req);
    @(negedge clk);
    cs_n = 1'b1; ld_a_n = 1'b1; ld_b_n = 1'b1;
    #1 clr_n = 1'b0;
    #1;
    chk({req, " R7 async dac_a"}, dac_a, '0);
    chk({req, " R7 async dac_b"}, dac_b, '0);
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    m_in[0] = '0; m_in[1] = '0; m_dac[0] = '0; m_dac[1] = '0;
    chk({req, " R8 dac_a"}, dac_a, '0);
    chk({req, " R8 dac_b"}, dac_b, '0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int a_edge, b_edge;
    logic [DW-1:0] pa, pb;
    void'($urandom(32'd7741));
    rst = 1'b1; clr_n = 1'b1; cs_n = 1'b1; sel_a = 1'b0; data = '0;
    ld_a_n = 1'b1; ld_b_n = 1'b1; shdn_n = 1'b1;
    m_in[0] = '0; m_in[1] = '0; m_dac[0] = '0; m_dac[1] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset dac_a", dac_a, '0);
    chk("R1 reset dac_b", dac_b, '0);
    chk("R1 reset out_en", {{(DW-1){1'b0}}, out_en}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_en one edge after reset", {{(DW-1){1'b0}}, out_en}, '0);
    @(negedge clk);
    chk("R1 out_en two edges after reset", {{(DW-1){1'b0}}, out_en}, 1);

    // R2 latency with channel A load held low
    step(1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b1, "R4 settle");
    @(negedge clk);
    cs_n = 1'b0; sel_a = 1'b1; data = 12'hA5C;
    repeat (3) @(negedge clk);
    chk("R2 before 4th edge", dac_a, '0);
    @(negedge clk);
    chk("R2 at 4th edge", dac_a, 12'hA5C);
    m_in[0] = 12'hA5C; m_dac[0] = 12'hA5C;

    // R5 close load A, stage B, change A behind the latch
    step(1'b1, 1'b1, 12'hA5C, 1'b1, 1'b1, 1'b1, "R5 close");
    step(1'b0, 1'b0, 12'h3C1, 1'b1, 1'b1, 1'b1, "R5 stage B");
    step(1'b1, 1'b1, 12'hFFF, 1'b1, 1'b1, 1'b1, "R3 cs high");
    step(1'b0, 1'b1, 12'h7E2, 1'b1, 1'b1, 1'b1, "R5 stage A");

    // R6 common strobe: both outputs change on the same edge
    @(negedge clk);
    ld_a_n = 1'b0; ld_b_n = 1'b0; cs_n = 1'b1;
    a_edge = -1; b_edge = -1; pa = dac_a; pb = dac_b;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (a_edge < 0 && dac_a !== pa) a_edge = k;
      if (b_edge < 0 && dac_b !== pb) b_edge = k;
    end
    chk("R6 same edge", DW'(a_edge), DW'(b_edge));
    chk("R6 dac_a", dac_a, 12'h7E2);
    chk("R6 dac_b", dac_b, 12'h3C1);
    m_dac[0] = 12'h7E2; m_dac[1] = 12'h3C1;

    step(1'b1, 1'b0, 12'h0F0, 1'b0, 1'b0, 1'b1, "R3 cs high transparent");
    step(1'b0, 1'b0, 12'hFFF, 1'b1, 1'b0, 1'b1, "R4 full scale B");
    // R5 load rises together with a new write: old word is kept
    step(1'b0, 1'b0, 12'h001, 1'b1, 1'b1, 1'b1, "R5 collide");
    step(1'b0, 1'b1, 12'h155, 1'b0, 1'b1, 1'b0, "R9 write in shutdown");
    step(1'b1, 1'b1, 12'h155, 1'b1, 1'b1, 1'b1, "R10 wake");

    clear_pulse("directed");
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b1, "R8 load after clear");

    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 9) == 0) clear_pulse("random");
      else step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                DW'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 3) != 0), "R2 R9 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule